// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synthesizable behavioural model of a synchronous static RAM whose bus never needs an idle cycle between a read and a write. Address and control are captured on the rising clock edge. The write data for a command arrives a fixed number of edges after that command, so that the write latency equals the read latency. Because of this, reads and writes can be issued on every cycle in any mix. The storage is a small register array built from one bank per 9-bit byte. Each byte has its own active-low write strobe.

A static mode input picks one of two timings. In pipelined timing, read data comes from an output register one edge after the read is captured, and write data is sampled two edges after the write command. In flow-through timing, read data is driven in the same cycle in which the address is held, and write data is sampled on the next edge. A pending write's address and byte strobes are held in the command pipeline. In pipelined timing, a read that lands on the edge where an older write to the same word commits receives the merged new data through a forwarding path.

Burst addresses come from a companion block on a separate input. The core selects that input when a cycle continues a burst. A clock-enable input stalls the whole core. An asynchronous output enable can silence the bus at any time.

Top module: `lw_sram_core`

## Requirements
- R1: While reset is low and after reset is released, `dq_oe` is 0. The array reads as zero everywhere, and no write is pending.
- R2: On a capturing edge with `adv_ld_n`=0, the core is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. With `we_n`=1 it starts a read at `addr`, and with `we_n`=0 it starts a write at `addr`. If any enable is inactive, the edge starts a deselect, and no data is driven for it.
- R3: In pipelined timing (`flow_mode`=0), the data for a read captured on edge n is driven with `dq_oe`=1 from edge n+1 until the next capturing edge.
- R4: In flow-through timing (`flow_mode`=1), the data for a read captured on edge n is driven from edge n until the next capturing edge.
- R5: In pipelined timing, `dq_in` for a write captured on edge n is sampled on capturing edge n+2.
- R6: In flow-through timing, `dq_in` for a write captured on edge n is sampled on capturing edge n+1.
- R7: Bit `bw_n[i]`=0 writes byte i, which is bits 9i+8..9i of the word. A write with every `bw_n` bit high is an abort and leaves the array unchanged.
- R8: An edge with `cke_n`=1 changes no state: the pending commands do not move, no write commits, and a driven read keeps being driven with the same data.
- R9: An edge with `adv_ld_n`=1 continues the previous command type at `burst_addr`, ignoring the chip enables. A continue directly after a deselect stays a deselect.
- R10: `oe_n`=1 forces `dq_oe` to 0 combinationally. `dq_oe` is also 0 in every cycle whose data slot belongs to a write, even with `oe_n` tied low.
- R11: In pipelined timing, a read of a word issued one cycle after a write to the same word returns that write's merged bytes, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low; high stalls the core |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write command when low, read when high |
| bw_n | input | NBYTES | Per-byte write strobes, active low |
| adv_ld_n | input | 1 | Low loads a new command, high continues the burst |
| oe_n | input | 1 | Asynchronous output enable, active low |
| flow_mode | input | 1 | Static timing select: 1 flow-through, 0 pipelined |
| addr | input | ADDR_W | External word address |
| burst_addr | input | ADDR_W | Next burst address from the companion counter |
| dq_in | input | NBYTES*BYTE_W | Write data bus (input half of the data pins) |
| dq_out | output | NBYTES*BYTE_W | Read data, zero when not driven |
| dq_oe | output | 1 | Drive enable for the data pins |

## Verification
The bench aims at a read placed one cycle after a write to the same word in pipelined timing. A core without the forwarding path would return the stale word there. It also stalls the clock enable while a read is on the bus and while a write waits for its data. A core that let either pipeline slip would drop the driven word or sample write data on the wrong edge. Partial and empty byte strobes check that untouched bytes survive. Bursts that follow a deselect check that the deselect does not turn into an access. Both timings run long random mixes against a queue-based model, so that any off-by-one in the read or write latency shows up as a wrong word or a wrong drive enable.

// File: rtl/lw_sram_pkg.sv
`timescale 1ns/1ps
package lw_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // all three enables must be in their active state
  function automatic logic chip_sel(input logic ce1_n, input logic ce2, input logic ce3_n);
    return (!ce1_n) && ce2 && (!ce3_n);
  endfunction

  function automatic op_e load_op(input logic sel, input logic we_n);
    if (!sel)      return OP_IDLE;
    else if (we_n) return OP_READ;
    else           return OP_WRITE;
  endfunction

endpackage

// File: rtl/lw_sram_decode.sv
`timescale 1ns/1ps
module lw_sram_decode
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2
) (
  input  logic              adv_ld_n,
  input  logic              we_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [NBYTES-1:0] bw_n,
  input  op_e               prev_op,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [NBYTES-1:0] cmd_be,
  output logic              sel
);

  assign sel    = chip_sel(ce1_n, ce2, ce3_n);
  assign cmd_be = ~bw_n;

  always_comb begin
    if (!adv_ld_n) begin
      cmd_op   = load_op(sel, we_n);
      cmd_addr = ext_addr;
    end else begin
      // continue: keep the type, deselect stays deselect
      cmd_op   = prev_op;
      cmd_addr = seq_addr;
    end
  end

endmodule

// File: rtl/lw_sram_stages.sv
`timescale 1ns/1ps
module lw_sram_stages
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  op_e               cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [NBYTES-1:0] cmd_be,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [NBYTES-1:0] s1_be,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [NBYTES-1:0] s2_be
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_be   <= '0;
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_be   <= '0;
    end else if (step) begin
      s1_op   <= cmd_op;
      s1_addr <= cmd_addr;
      s1_be   <= cmd_be;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

endmodule

// File: rtl/lw_sram_array.sv
`timescale 1ns/1ps
module lw_sram_array #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NBYTES-1:0]        wr_be,
  input  logic [NBYTES*BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [NBYTES*BYTE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_bank
    logic [BYTE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
      end else if (wr_en && wr_be[b]) begin
        bank[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
      end
    end

    assign rd_data[b*BYTE_W +: BYTE_W] = bank[rd_addr];
  end

endmodule

// File: rtl/lw_sram_core.sv
`timescale 1ns/1ps
module lw_sram_core
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke_n,
  input  logic                     ce1_n,
  input  logic                     ce2,
  input  logic                     ce3_n,
  input  logic                     we_n,
  input  logic [NBYTES-1:0]        bw_n,
  input  logic                     adv_ld_n,
  input  logic                     oe_n,
  input  logic                     flow_mode,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [ADDR_W-1:0]        burst_addr,
  input  logic [NBYTES*BYTE_W-1:0] dq_in,
  output logic [NBYTES*BYTE_W-1:0] dq_out,
  output logic                     dq_oe
);

  localparam int DATA_W = NBYTES * BYTE_W;

  // replace the strobed bytes of a stored word with new bytes
  function automatic logic [DATA_W-1:0] merge_bytes(input logic [DATA_W-1:0] old_w,
                                                    input logic [DATA_W-1:0] new_w,
                                                    input logic [NBYTES-1:0] be);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int b = 0; b < NBYTES; b++)
      if (be[b]) r[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  logic              step;
  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [NBYTES-1:0] cmd_be;
  logic              sel;
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [NBYTES-1:0] s1_be, s2_be;

  assign step = !cke_n;

  lw_sram_decode #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_decode (
    .adv_ld_n (adv_ld_n),
    .we_n     (we_n),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .ext_addr (addr),
    .seq_addr (burst_addr),
    .bw_n     (bw_n),
    .prev_op  (s1_op),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr),
    .cmd_be   (cmd_be),
    .sel      (sel)
  );

  lw_sram_stages #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_stages (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr),
    .cmd_be   (cmd_be),
    .s1_op    (s1_op),
    .s1_addr  (s1_addr),
    .s1_be    (s1_be),
    .s2_op    (s2_op),
    .s2_addr  (s2_addr),
    .s2_be    (s2_be)
  );

  // the stage whose command owns the data slot this cycle
  op_e               data_op;
  logic [ADDR_W-1:0] data_addr;
  logic [NBYTES-1:0] data_be;
  logic              data_phase_wr;
  logic              commit_en;

  assign data_op       = flow_mode ? s1_op   : s2_op;
  assign data_addr     = flow_mode ? s1_addr : s2_addr;
  assign data_be       = flow_mode ? s1_be   : s2_be;
  assign data_phase_wr = (data_op == OP_WRITE);
  assign commit_en     = step && data_phase_wr;

  logic [DATA_W-1:0] arr_rd_data;

  lw_sram_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (commit_en),
    .wr_addr (data_addr),
    .wr_be   (data_be),
    .wr_data (dq_in),
    .rd_addr (s1_addr),
    .rd_data (arr_rd_data)
  );

  // forwarding: pipelined read meets the write committing on the same edge
  logic              bypass_hit;
  logic [DATA_W-1:0] fwd_word;
  logic [DATA_W-1:0] q_reg;

  assign bypass_hit = !flow_mode && (s1_op == OP_READ) && (s2_op == OP_WRITE)
                      && (s2_addr == s1_addr);
  assign fwd_word   = bypass_hit ? merge_bytes(arr_rd_data, dq_in, s2_be) : arr_rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        q_reg <= '0;
    else if (step && !flow_mode && s1_op == OP_READ)   q_reg <= fwd_word;
  end

  logic rd_drive;
  assign rd_drive = (data_op == OP_READ);
  assign dq_oe    = rd_drive && !oe_n;
  assign dq_out   = dq_oe ? (flow_mode ? arr_rd_data : q_reg) : '0;

  // ---------------- assertions ----------------
  a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |-> !dq_oe)
    else $error("R1: bus driven during reset");

  a_r10_write_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase_wr |-> !dq_oe)
    else $error("R10: bus driven in a write data slot");

  a_r10_oe_override: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe)
    else $error("R10: bus driven with output enable off");

  a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(s1_op) && $stable(s1_addr) && $stable(s2_op) && $stable(q_reg)))
    else $error("R8: state moved during a stalled edge");

  a_r2_deselect_load: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !adv_ld_n && !sel) |=> (s1_op == OP_IDLE))
    else $error("R2: deselected load became an access");

  a_r9_deselect_continue: assert property (@(posedge clk) disable iff (!rst_n)
    (step && adv_ld_n && s1_op == OP_IDLE) |=> (s1_op == OP_IDLE))
    else $error("R9: continue after deselect became an access");

endmodule

// File: tb/tb_lw_sram_core.sv
`timescale 1ns/1ps
module tb_lw_sram_core;

  localparam int AW = 6;
  localparam int BW = 9;
  localparam int NB = 2;
  localparam int DW = NB * BW;
  localparam int K_RD = 0, K_WR = 1, K_DS = 2, K_CON = 3, K_HLD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke_n = 1'b0, ce1_n = 1'b1, ce2 = 1'b1, ce3_n = 1'b0;
  logic          we_n = 1'b1, adv_ld_n = 1'b0, oe_n = 1'b0, flow_mode = 1'b0;
  logic [NB-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0, burst_addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  always #10 clk = ~clk;   // 50 MHz

  lw_sram_core dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .we_n(we_n), .bw_n(bw_n), .adv_ld_n(adv_ld_n), .oe_n(oe_n), .flow_mode(flow_mode),
    .addr(addr), .burst_addr(burst_addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int    vectors = 0;
  int    fails   = 0;
  bit    done    = 1'b0;
  string cur_req = "R1";

  // ---------------- reference model ----------------
  logic [DW-1:0] rmem [1<<AW];
  int            cnt;
  int            last_kind;         // 0 deselect, 1 read, 2 write
  int            wq_due[$];
  int            wq_addr[$];
  logic [NB-1:0] wq_be[$];
  int            rq_vis[$];
  int            rq_addr[$];
  bit            exp_rd;
  logic [DW-1:0] exp_val;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) rmem[i] = '0;
      cnt = 0; last_kind = 0; exp_rd = 0; exp_val = '0;
      wq_due.delete(); wq_addr.delete(); wq_be.delete();
      rq_vis.delete(); rq_addr.delete();
    end else if (!cke_n) begin
      int k;
      int a;
      cnt++;
      while (wq_due.size() > 0 && wq_due[0] == cnt) begin
        for (int b = 0; b < NB; b++)
          if (wq_be[0][b]) rmem[wq_addr[0]][b*BW +: BW] = dq_in[b*BW +: BW];
        void'(wq_due.pop_front()); void'(wq_addr.pop_front()); void'(wq_be.pop_front());
      end
      if (!adv_ld_n) begin
        k = (ce1_n == 0 && ce2 == 1 && ce3_n == 0) ? (we_n ? 1 : 2) : 0;
        a = int'(addr);
      end else begin
        k = last_kind;
        a = int'(burst_addr);
      end
      last_kind = k;
      if (k == 2) begin
        wq_due.push_back(cnt + (flow_mode ? 1 : 2));
        wq_addr.push_back(a);
        wq_be.push_back(~bw_n);
      end else if (k == 1) begin
        rq_vis.push_back(cnt + (flow_mode ? 0 : 1));
        rq_addr.push_back(a);
      end
      exp_rd = 0;
      if (rq_vis.size() > 0 && rq_vis[0] == cnt) begin
        exp_rd  = 1;
        exp_val = rmem[rq_addr[0]];
        void'(rq_vis.pop_front()); void'(rq_addr.pop_front());
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    #3;
    if (!done) begin
      vectors++;
      if (!rst_n) begin
        if (dq_oe !== 1'b0) begin
          fails++;
          $display("FAIL R1: dq_oe=%0b expected 0 in reset", dq_oe);
        end
      end else begin
        bit eo;
        eo = exp_rd && !oe_n;
        if (dq_oe !== eo) begin
          fails++;
          $display("FAIL %s: dq_oe=%0b expected %0b at t=%0t", cur_req, dq_oe, eo, $time);
        end else if (eo && dq_out !== exp_val) begin
          fails++;
          $display("FAIL %s: dq_out=%h expected %h at t=%0t", cur_req, dq_out, exp_val, $time);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic op(input int kind, input int a, input logic [NB-1:0] bwn,
                    input logic [DW-1:0] din, input int dsv);
    @(negedge clk);
    cke_n = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; adv_ld_n = 0; we_n = 1;
    bw_n = bwn; addr = AW'(a); burst_addr = AW'(a); dq_in = din;
    case (kind)
      K_WR:  we_n = 0;
      K_DS:  begin
               if (dsv == 0) ce1_n = 1;
               else if (dsv == 1) ce2 = 0;
               else ce3_n = 1;
             end
      K_CON: begin
               adv_ld_n = 1; addr = AW'(a) ^ {AW{1'b1}};
               ce1_n = 1;   // enables ignored on continue
             end
      K_HLD: cke_n = 1;
      default: ;
    endcase
  endtask

  task automatic do_reset(input logic fm);
    @(negedge clk);
    rst_n = 0; flow_mode = fm; ce1_n = 1; adv_ld_n = 0; cke_n = 0; oe_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic random_mix(input int n);
    for (int i = 0; i < n; i++) begin
      int r;
      logic [DW-1:0] d;
      r = $urandom_range(0, 15);
      d = DW'($urandom);
      oe_n = ($urandom_range(0, 7) == 0);
      if (r <= 4)       op(K_RD, $urandom_range(0, 7), 2'b11, d, 0);
      else if (r <= 8)  op(K_WR, $urandom_range(0, 7), NB'($urandom), d, 0);
      else if (r <= 10) op(K_DS, 0, 2'b11, d, $urandom_range(0, 2));
      else if (r <= 13) op(K_CON, $urandom_range(0, 7), NB'($urandom), d, 0);
      else              op(K_HLD, 0, 2'b11, d, 0);
    end
    oe_n = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    cur_req = "R1";
    do_reset(1'b0);
    op(K_RD, 5, 2'b11, '0, 0);
    op(K_RD, 6, 2'b11, '0, 0);
    op(K_DS, 0, 2'b11, '0, 0);

    // pipelined writes then reads (R3, R5)
    cur_req = "R3 R5";
    op(K_WR, 1, 2'b00, '0, 0);
    op(K_WR, 2, 2'b00, '0, 0);
    op(K_RD, 1, 2'b11, 18'h2_1111, 0);
    op(K_RD, 2, 2'b11, 18'h1_2222, 0);
    op(K_DS, 0, 2'b11, '0, 0);

    // forwarding: read right after write to same word (R11)
    cur_req = "R11";
    op(K_WR, 3, 2'b00, '0, 0);
    op(K_RD, 3, 2'b11, '0, 0);
    op(K_RD, 3, 2'b11, 18'h3_0F0F, 0);
    op(K_DS, 0, 2'b11, '0, 0);
    op(K_WR, 3, 2'b01, '0, 0);
    op(K_RD, 3, 2'b11, '0, 0);
    op(K_DS, 0, 2'b11, 18'h0_1ABC, 0);
    op(K_DS, 0, 2'b11, '0, 0);

    // byte strobes and abort (R7)
    cur_req = "R7";
    op(K_WR, 9, 2'b00, '0, 0);
    op(K_WR, 9, 2'b10, '0, 0);
    op(K_WR, 9, 2'b11, 18'h2_AAAA, 0);
    op(K_RD, 9, 2'b11, 18'h1_5555, 0);
    op(K_RD, 9, 2'b11, 18'h3_FFFF, 0);
    op(K_DS, 0, 2'b11, '0, 0);
    op(K_RD, 9, 2'b11, '0, 0);
    op(K_DS, 0, 2'b11, '0, 0);

    // each chip enable alone deselects (R2)
    cur_req = "R2";
    for (int e = 0; e < 3; e++) begin
      op(K_DS, 1, 2'b00, 18'h3_3333, e);
      op(K_RD, 2, 2'b11, '0, 0);
    end
    op(K_DS, 0, 2'b00, '0, 1);
    op(K_DS, 0, 2'b11, '0, 2);

    // bursts (R9)
    cur_req = "R9";
    op(K_CON, 1, 2'b00, '0, 0);
    op(K_CON, 2, 2'b00, '0, 0);
    op(K_RD, 4, 2'b11, '0, 0);
    op(K_CON, 1, 2'b11, '0, 0);
    op(K_CON, 2, 2'b11, '0, 0);
    op(K_WR, 12, 2'b00, '0, 0);
    op(K_CON, 13, 2'b00, '0, 0);
    op(K_RD, 12, 2'b11, 18'h0_0C0C, 0);
    op(K_CON, 13, 2'b11, 18'h0_0D0D, 0);
    op(K_DS, 0, 2'b11, '0, 0);

    // stalls (R8)
    cur_req = "R8";
    op(K_RD, 12, 2'b11, '0, 0);
    op(K_HLD, 0, 2'b11, '0, 0);
    op(K_HLD, 0, 2'b11, '0, 0);
    op(K_RD, 13, 2'b11, '0, 0);
    op(K_HLD, 0, 2'b11, '0, 0);
    op(K_HLD, 0, 2'b11, '0, 0);
    op(K_WR, 20, 2'b00, '0, 0);
    op(K_HLD, 0, 2'b11, 18'h1_DEAD, 0);
    op(K_DS, 0, 2'b11, 18'h1_DEAD, 0);
    op(K_HLD, 0, 2'b11, 18'h0_BEEF, 0);
    op(K_RD, 20, 2'b11, 18'h0_BEEF, 0);
    op(K_DS, 0, 2'b11, '0, 0);
    op(K_DS, 0, 2'b11, '0, 0);

    // output enable (R10)
    cur_req = "R10";
    op(K_RD, 1, 2'b11, '0, 0);
    oe_n = 1;
    op(K_RD, 2, 2'b11, '0, 0);
    oe_n = 0;
    op(K_WR, 4, 2'b00, '0, 0);
    op(K_RD, 4, 2'b11, '0, 0);
    op(K_WR, 5, 2'b00, 18'h2_4444, 0);
    op(K_DS, 0, 2'b11, '0, 0);
    op(K_DS, 0, 2'b11, '0, 0);

    cur_req = "R11 pipelined random";
    random_mix(500);

    // flow-through timing (R4, R6)
    cur_req = "R1";
    do_reset(1'b1);
    op(K_RD, 7, 2'b11, '0, 0);
    cur_req = "R4 R6";
    op(K_WR, 7, 2'b00, '0, 0);
    op(K_RD, 7, 2'b11, 18'h1_7777, 0);
    op(K_WR, 8, 2'b01, '0, 0);
    op(K_RD, 8, 2'b11, 18'h3_8888, 0);
    op(K_RD, 7, 2'b11, '0, 0);
    op(K_HLD, 0, 2'b11, '0, 0);
    op(K_WR, 6, 2'b00, '0, 0);
    op(K_HLD, 0, 2'b11, 18'h0_0001, 0);
    op(K_RD, 6, 2'b11, 18'h2_6666, 0);
    op(K_CON, 7, 2'b11, '0, 0);
    op(K_DS, 0, 2'b11, '0, 0);

    cur_req = "R6 R7 R9 flow random";
    random_mix(500);
    op(K_DS, 0, 2'b11, '0, 0);
    op(K_DS, 0, 2'b11, '0, 0);

    @(negedge clk);
    #5;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule